// File: doc/BRIEF.md
# Parallel Reed-Solomon FEC Encoder, RS(528,514), 16 Symbols per Clock

This block is a systematic Reed-Solomon encoder for the forward error correction sublayer of a 100G Ethernet backplane link. Each codeword has 514 message symbols and 14 parity symbols, and every symbol is 10 bits wide. The code corrects up to 7 symbol errors at the receiver. Every clock the block takes in sixteen symbols on a 160-bit bus, so a codeword takes 33 beats. A single-cycle start pulse marks the first beat of each codeword.

The message symbols pass through unchanged. Near the end of the final beat the block switches from message to parity. In that beat the first two lanes still carry message symbols and the last fourteen lanes carry the computed parity. The parity remainder takes in a whole 16-symbol step in one cycle. It is built by unrolling the serial division step in combinational logic, and a tap partway along the chain serves the short final beat.

A clock enable freezes the whole block. An asynchronous reset returns it to an idle state, in which data is passed through unchanged.

Top module: `rs528Encoder`

## Requirements
- R1: The asynchronous reset forces `dataOut` to all zeros at once, without waiting for a clock edge, and leaves the block idle.
- R2: A beat sampled on an enabled rising edge appears on `dataOut` after the third enabled rising edge, counting the sampling edge as the first. Before that, the output still shows older data.
- R3: Message symbols pass through unchanged: all sixteen lanes of beats 0 to 31, and lanes 0 and 1 of beat 32.
- R4: Lanes 2 to 15 of beat 32 carry the parity. Parity is computed in GF(2^10) with the reduction polynomial x^10+x^3+1 and the generator g(x)=(x+α^0)(x+α^1)...(x+α^13), where α=2. Lane 2 holds the coefficient of x^13 of the remainder and lane 15 holds the coefficient of x^0. Each complete output codeword, read as a polynomial, evaluates to zero at α^0 through α^13.
- R5: The input symbols in lanes 2 to 15 of beat 32 have no effect on any output.
- R6: While `clkEn` is low, every input is ignored, including `frameStart`. The internal state does not advance and `dataOut` holds its value.
- R7: A `frameStart` pulse on an enabled edge always begins a new codeword at beat 0, even in the middle of another codeword. The partial remainder from the interrupted codeword is discarded.
- R8: Symbol order is fixed. Lane 0 occupies bits [9:0] and comes first in time. Symbol k of the codeword sits in beat k/16, lane k%16. Symbol 0 is the highest-degree coefficient. A codeword covers the start beat and the next 32 enabled beats.
- R9: The block is idle before the first start pulse, and again after beat 32 until the next start pulse. While idle, every beat passes through unchanged and no parity is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rstAsync | input | 1 | Asynchronous reset, active high |
| clkEn | input | 1 | Synchronous enable; low freezes the block |
| frameStart | input | 1 | Single-cycle pulse on the first beat of a codeword |
| dataIn | input | 160 | Sixteen 10-bit input symbols, lane 0 in bits [9:0] |
| dataOut | output | 160 | Sixteen 10-bit output symbols, same lane layout |

## Verification
The bench builds the block with its default parameters: 10-bit symbols, sixteen lanes, 514 message symbols and 14 parity symbols. With these values the message-to-parity switch falls after lane 1 of the 33rd beat, so the short tap of the unrolled chain is exercised as well as the full sixteen-step path. These values also let the bench compare every output beat against an independent symbol-serial encoder, and evaluate each complete output codeword at all fourteen generator roots. Other scenarios run the same 33-beat cadence through enable gaps, start pulses that arrive while the enable is low, restarts in mid-codeword, an all-zero message, and a message with a single unit symbol, whose parity must equal the low coefficients of g(x).

// File: rtl/rsEncPkg.sv
package rsEncPkg;

  // Strobes from the beat sequencer to the datapath, valid for the beat in the input register
  typedef struct packed {
    logic absorb;  // beat belongs to a codeword: update the remainder
    logic clear;   // first beat: start the remainder from zero
    logic last;    // final beat: only the leading message lanes feed the remainder
  } encStrobe_t;

  // Galois-field product used only at elaboration time
  function automatic int gfMulInt(input int a, input int b, input int symW, input int poly);
    int acc;
    int x;
    acc = 0;
    x = a;
    for (int i = 0; i < symW; i++) begin
      if (((b >> i) & 1) != 0) acc = acc ^ x;
      x = x << 1;
      if (((x >> symW) & 1) != 0) x = x ^ poly;
    end
    return acc;
  endfunction

  // Coefficient k of prod_{i=0}^{nPar-1} (x + alpha^i), alpha = 2
  function automatic int genCoeff(input int k, input int nPar, input int symW, input int poly);
    int g [0:63];
    int root;
    for (int i = 0; i < 64; i++) g[i] = 0;
    g[0] = 1;
    root = 1;
    for (int i = 0; i < nPar; i++) begin
      for (int j = nPar; j >= 1; j--) g[j] = g[j-1] ^ gfMulInt(g[j], root, symW, poly);
      g[0] = gfMulInt(g[0], root, symW, poly);
      root = gfMulInt(root, 2, symW, poly);
    end
    return g[k];
  endfunction

endpackage

// File: rtl/rsEncCtrl.sv
module rsEncCtrl #(
  parameter int BEATS = 33
) (
  input  logic                 clk,
  input  logic                 rstAsync,
  input  logic                 clkEn,
  input  logic                 frameStart,
  output rsEncPkg::encStrobe_t strb
);
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(BEATS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  // Index of the beat that sits in the datapath input register
  logic [CNT_W-1:0] beatQ;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) begin
      beatQ <= IDLE;
    end else if (clkEn) begin
      if (frameStart)          beatQ <= '0;
      else if (beatQ != IDLE)  beatQ <= beatQ + CNT_W'(1);
    end
  end

  always_comb begin
    strb.absorb = (beatQ != IDLE);
    strb.clear  = (beatQ == '0);
    strb.last   = (beatQ == LAST);
  end

  // R7: a sampled start always opens beat 0 on the next cycle
  p_start_restart_r7: assert property (@(posedge clk) disable iff (rstAsync)
    (clkEn && frameStart) |=> strb.clear);

  // R9: idle persists until a start pulse
  p_idle_sticky_r9: assert property (@(posedge clk) disable iff (rstAsync)
    (clkEn && !frameStart && !strb.absorb) |=> !strb.absorb);

  // R8: the final beat is reached only from the beat before it
  p_last_order_r8: assert property (@(posedge clk) disable iff (rstAsync)
    $rose(strb.last) |-> ($past(beatQ) == LAST - CNT_W'(1)));

  // R6: sequencer frozen while disabled
  p_seq_frozen_r6: assert property (@(posedge clk) disable iff (rstAsync)
    !clkEn |=> $stable(beatQ));

endmodule

// File: rtl/rsEncDatapath.sv
module rsEncDatapath #(
  parameter int SYM_W     = 10,
  parameter int LANES     = 16,
  parameter int MSG_SYMS  = 514,
  parameter int PAR_SYMS  = 14,
  parameter int PRIM_POLY = 'h409
) (
  input  logic                       clk,
  input  logic                       rstAsync,
  input  logic                       clkEn,
  input  rsEncPkg::encStrobe_t       strb,
  input  logic [SYM_W*LANES-1:0]     dataIn,
  output logic [SYM_W*LANES-1:0]     dataOut
);
  localparam int BEATS      = (MSG_SYMS + PAR_SYMS) / LANES;
  localparam int LAST_LANES = MSG_SYMS - (BEATS - 1) * LANES;
  localparam logic [SYM_W-1:0] POLY_LOW = SYM_W'(PRIM_POLY);

  // Multiply a symbol by a (constant) field element
  function automatic logic [SYM_W-1:0] mulConst(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] c);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] x;
    acc = '0;
    x   = c;
    for (int i = 0; i < SYM_W; i++) begin
      if (a[i]) acc = acc ^ x;
      x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? POLY_LOW : '0);
    end
    return acc;
  endfunction

  logic [LANES-1:0][SYM_W-1:0]    dinQ;
  logic [LANES-1:0][SYM_W-1:0]    msgQ;
  logic [LANES-1:0][SYM_W-1:0]    outQ;
  logic [LANES-1:0][SYM_W-1:0]    outNext;
  logic [PAR_SYMS-1:0][SYM_W-1:0] remQ;
  logic [PAR_SYMS-1:0][SYM_W-1:0] nextRem;
  logic [PAR_SYMS-1:0][SYM_W-1:0] chainRem [LANES+1];
  logic [SYM_W-1:0]               feedback [LANES];
  logic [SYM_W-1:0]               genC [PAR_SYMS];
  logic                           lastQ;

  // Generator taps, fixed at elaboration
  for (genvar j = 0; j < PAR_SYMS; j++) begin : g_gen
    localparam logic [SYM_W-1:0] COEF =
      SYM_W'(rsEncPkg::genCoeff(j, PAR_SYMS, SYM_W, PRIM_POLY));
    assign genC[j] = COEF;
  end

  // Unrolled division chain: one serial step per lane, lane 0 first
  assign chainRem[0] = strb.clear ? '0 : remQ;

  for (genvar s = 0; s < LANES; s++) begin : g_step
    assign feedback[s] = dinQ[s] ^ chainRem[s][PAR_SYMS-1];
    for (genvar j = 0; j < PAR_SYMS; j++) begin : g_tap
      if (j == 0) begin : g_low
        assign chainRem[s+1][0] = mulConst(feedback[s], genC[0]);
      end else begin : g_up
        assign chainRem[s+1][j] = chainRem[s][j-1] ^ mulConst(feedback[s], genC[j]);
      end
    end
  end

  // Final beat stops after the leading message lanes
  assign nextRem = strb.last ? chainRem[LAST_LANES] : chainRem[LANES];

  // Output lane select: parity replaces the trailing lanes of the final beat
  for (genvar l = 0; l < LANES; l++) begin : g_out
    if (l < LAST_LANES) begin : g_msg
      assign outNext[l] = msgQ[l];
    end else begin : g_par
      assign outNext[l] = lastQ ? remQ[PAR_SYMS-1-(l-LAST_LANES)] : msgQ[l];
    end
  end

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) begin
      dinQ  <= '0;
      msgQ  <= '0;
      remQ  <= '0;
      lastQ <= 1'b0;
      outQ  <= '0;
    end else if (clkEn) begin
      dinQ  <= dataIn;
      msgQ  <= dinQ;
      lastQ <= strb.last;
      if (strb.absorb) remQ <= nextRem;
      outQ  <= outNext;
    end
  end

  assign dataOut = outQ;

  // R6: nothing moves while disabled
  p_freeze_r6: assert property (@(posedge clk) disable iff (rstAsync)
    !clkEn |=> ($stable(outQ) && $stable(remQ)));

  // R1: output never unknown once out of reset
  p_known_r1: assert property (@(posedge clk) disable iff (rstAsync)
    !$isunknown(outQ));

  // R9: remainder untouched by idle beats
  p_rem_idle_r9: assert property (@(posedge clk) disable iff (rstAsync)
    (clkEn && !strb.absorb) |=> $stable(remQ));

endmodule

// File: rtl/rs528Encoder.sv
module rs528Encoder #(
  parameter int SYM_W     = 10,
  parameter int LANES     = 16,
  parameter int MSG_SYMS  = 514,
  parameter int PAR_SYMS  = 14,
  parameter int PRIM_POLY = 'h409
) (
  input  logic                   clk,
  input  logic                   rstAsync,
  input  logic                   clkEn,
  input  logic                   frameStart,
  input  logic [SYM_W*LANES-1:0] dataIn,
  output logic [SYM_W*LANES-1:0] dataOut
);
  localparam int BEATS = (MSG_SYMS + PAR_SYMS) / LANES;

  rsEncPkg::encStrobe_t strb;

  rsEncCtrl #(
    .BEATS(BEATS)
  ) u_ctrl (
    .clk       (clk),
    .rstAsync  (rstAsync),
    .clkEn     (clkEn),
    .frameStart(frameStart),
    .strb      (strb)
  );

  rsEncDatapath #(
    .SYM_W    (SYM_W),
    .LANES    (LANES),
    .MSG_SYMS (MSG_SYMS),
    .PAR_SYMS (PAR_SYMS),
    .PRIM_POLY(PRIM_POLY)
  ) u_dp (
    .clk     (clk),
    .rstAsync(rstAsync),
    .clkEn   (clkEn),
    .strb    (strb),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/sim_rs528Encoder.sv
module sim_rs528Encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 514;
  localparam int NP = 14;
  localparam int NB = 33;
  localparam int SLOTS = 4096;

  logic clk = 1'b0;
  logic rstAsync = 1'b1;
  logic clkEn = 1'b0;
  logic frameStart = 1'b0;
  logic [159:0] dataIn = '0;
  logic [159:0] dataOut;

  int nChecks = 0;
  int nFails = 0;
  int edgeCnt = 0;
  bit done = 0;

  logic [159:0] expBeat [0:SLOTS-1];
  logic         expValid [0:SLOTS-1];
  string        expTag [0:SLOTS-1];
  logic [159:0] capBeat [0:SLOTS-1];
  logic [159:0] lastOut = '0;
  int gPoly [0:14];
  int cw [0:527];

  rs528Encoder u0 (
    .clk(clk), .rstAsync(rstAsync), .clkEn(clkEn),
    .frameStart(frameStart), .dataIn(dataIn), .dataOut(dataOut)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic int gfMul(input int a, input int b);
    int acc = 0;
    int x = a;
    int y = b;
    while (y != 0) begin
      if ((y & 1) != 0) acc = acc ^ x;
      y = y >> 1;
      x = x << 1;
      if ((x & 'h400) != 0) x = x ^ 'h409;
    end
    return acc;
  endfunction

  function automatic logic [159:0] rnd160();
    return {$urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  // Symbol-serial reference: fills cw[NM..527] from cw[0..NM-1]
  function automatic void refEncode();
    int r [0:13];
    int fb;
    for (int j = 0; j < NP; j++) r[j] = 0;
    for (int k = 0; k < NM; k++) begin
      fb = cw[k] ^ r[13];
      for (int j = 13; j >= 1; j--) r[j] = r[j-1] ^ gfMul(fb, gPoly[j]);
      r[0] = gfMul(fb, gPoly[0]);
    end
    for (int j = 0; j < NP; j++) cw[NM + j] = r[13 - j];
  endfunction

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setExp(input int slot, input logic [159:0] v, input string t);
    expBeat[slot]  = v;
    expValid[slot] = 1'b1;
    expTag[slot]   = t;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic step(input logic s, input logic [159:0] d, input logic e);
    frameStart = s;
    dataIn     = d;
    clkEn      = e;
    @(posedge clk);
    if (e) edgeCnt++;
    @(negedge clk);
    if (e) begin
      capBeat[edgeCnt] = dataOut;
      if (expValid[edgeCnt]) check(expTag[edgeCnt], dataOut, expBeat[edgeCnt]);
    end else begin
      check("R6 output held while disabled", dataOut, lastOut);
    end
    lastOut = dataOut;
  endtask

  task automatic idleBeats(input int n);
    for (int i = 0; i < n; i++) begin
      logic [159:0] d;
      d = rnd160();
      setExp(edgeCnt + 3, d, "R9 idle passthrough");
      step(1'b0, d, 1'b1);
    end
  endtask

  // mode 0: random message, 1: all zero, 2: single unit symbol at the end
  task automatic sendCodeword(input string tag, input int mode, input int gapPct,
                              input int stopAfter, output int firstSlot);
    for (int k = 0; k < NM; k++) cw[k] = (mode == 0) ? int'($urandom % 1024) : 0;
    if (mode == 2) cw[NM-1] = 1;
    refEncode();
    firstSlot = edgeCnt + 3;
    for (int b = 0; b < NB && b < stopAfter; b++) begin
      logic [159:0] inBeat;
      logic [159:0] outBeat;
      for (int l = 0; l < 16; l++) begin
        outBeat[l*10 +: 10] = 10'(cw[b*16 + l]);
        inBeat[l*10 +: 10]  = (b == NB-1 && l >= 2) ? 10'($urandom) : 10'(cw[b*16 + l]);
      end
      while (gapPct > 0 && int'($urandom % 100) < gapPct)
        step(1'($urandom % 2), rnd160(), 1'b0);
      if (b == 0) firstSlot = edgeCnt + 3;
      if (b == NB-1) setExp(edgeCnt + 3, outBeat, {tag, " R4 parity lanes / R5 ignored lanes"});
      else           setExp(edgeCnt + 3, outBeat, {tag, " R3 message lanes, R8 order"});
      step(b == 0, inBeat, 1'b1);
    end
  endtask

  task automatic syndromeCheck(input int slot, input string tag);
    for (int i = 0; i < NP; i++) begin
      int beta = 1;
      int acc = 0;
      for (int p = 0; p < i; p++) beta = gfMul(beta, 2);
      for (int k = 0; k < 528; k++) begin
        logic [159:0] bt;
        bt = capBeat[slot + k/16];
        acc = gfMul(acc, beta) ^ int'(bt[(k%16)*10 +: 10]);
      end
      checkInt({tag, " R4 codeword root"}, acc, 0);
    end
  endtask

  task automatic testLatency();
    logic [159:0] p;
    p = rnd160();
    setExp(edgeCnt + 1, '0, "R2 not yet at edge 1");
    setExp(edgeCnt + 2, '0, "R2 not yet at edge 2");
    setExp(edgeCnt + 3, p,  "R2 visible after third edge");
    step(1'b0, p, 1'b1);
    setExp(edgeCnt + 3, '0, "R2 trailing zero");
    step(1'b0, '0, 1'b1);
    setExp(edgeCnt + 3, '0, "R2 trailing zero");
    step(1'b0, '0, 1'b1);
  endtask

  task automatic testIdle();
    idleBeats(5);
  endtask

  task automatic testSingleWord();
    int s;
    sendCodeword("single", 0, 0, NB, s);
    idleBeats(3);
    syndromeCheck(s, "single");
    sendCodeword("single again new garbage", 0, 0, NB, s);
    idleBeats(3);
    syndromeCheck(s, "single again");
  endtask

  task automatic testZeroAndUnit();
    int s;
    sendCodeword("zero message", 1, 0, NB, s);
    idleBeats(3);
    check("R4 zero message parity", capBeat[s + 32] >> 20, '0);
    sendCodeword("unit message", 2, 0, NB, s);
    idleBeats(3);
    for (int j = 0; j < NP; j++)
      checkInt("R4 unit message parity equals generator tap",
               int'(capBeat[s + 32][(2 + j)*10 +: 10]), gPoly[13 - j]);
  endtask

  task automatic testBackToBack();
    int s1;
    int s2;
    sendCodeword("b2b first", 0, 0, NB, s1);
    sendCodeword("b2b second", 0, 0, NB, s2);
    idleBeats(3);
    syndromeCheck(s1, "b2b first");
    syndromeCheck(s2, "b2b second");
  endtask

  task automatic testGaps();
    int s;
    sendCodeword("R6 gaps", 0, 40, NB, s);
    idleBeats(3);
    syndromeCheck(s, "R6 gaps");
  endtask

  task automatic testRestart();
    int s;
    sendCodeword("R7 aborted", 0, 0, 10, s);
    sendCodeword("R7 restarted", 0, 0, NB, s);
    idleBeats(3);
    syndromeCheck(s, "R7 restarted");
  endtask

  task automatic testMidReset();
    int s;
    sendCodeword("R1 before reset", 0, 0, 5, s);
    rstAsync = 1'b1;
    #1;
    check("R1 asynchronous clear", dataOut, '0);
    for (int k = 1; k <= 3; k++) expValid[edgeCnt + k] = 1'b0;
    @(negedge clk);
    check("R1 output zero in reset", dataOut, '0);
    rstAsync = 1'b0;
    lastOut = dataOut;
    sendCodeword("R1 after reset", 0, 0, NB, s);
    idleBeats(3);
    syndromeCheck(s, "R1 after reset");
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) expValid[i] = 1'b0;
    for (int j = 0; j <= NP; j++) gPoly[j] = 0;
    gPoly[0] = 1;
    begin
      int root = 1;
      for (int i = 0; i < NP; i++) begin
        for (int j = NP; j >= 1; j--) gPoly[j] = gPoly[j-1] ^ gfMul(gPoly[j], root);
        gPoly[0] = gfMul(gPoly[0], root);
        root = gfMul(root, 2);
      end
    end
    repeat (3) @(negedge clk);
    check("R1 reset output", dataOut, '0);
    rstAsync = 1'b0;
    lastOut = dataOut;
    testLatency();
    testIdle();
    testSingleWord();
    testZeroAndUnit();
    testBackToBack();
    testGaps();
    testRestart();
    testMidReset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (R1..R9 run): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule